// File: doc/BRIEF.md
# Latched event interrupt controller

This block gathers seven event sources into a single interrupt pulse. The sources are four capture events, a counter overflow, a count-equals-period match and a count-equals-compare match. Each event sets a sticky flag. The flags latch whether or not their source is enabled. The enable bits only decide which flags may raise the interrupt.

A global flag gates the output. When the controller issues a pulse, it sets the global flag in the same cycle. No further pulse is possible until software clears the global flag through the clear register. Software clears the serviced event flags through the same register. Any flag can also be set through a force register, for test.

The overflow source is not a pin. The block detects it by watching the counter value pass from all ones to zero. Software reaches the block through three write strobes, each with its own data word. The enable and flag registers are always visible on output ports.

Top module: `evt_irq_ctl`

## Requirements
- R1: After reset, en_o is 0, flag_o is 0 and irq_o is 0.
- R2: A high bit of evt_i sets its event flag at the next clock edge, whether or not that source is enabled. The bit mapping is: evt_i[3:0] (capture 1..4) to flag_o[4:1], evt_i[4] (period match) to flag_o[6], evt_i[5] (compare match) to flag_o[7].
- R3: flag_o[5] (overflow) is set at the edge where cnt_i equals 0 and cnt_i on the previous edge was all ones. No other transition of cnt_i sets it, including a jump to 0 from any other value.
- R4: While the global flag flag_o[0] is 0 and some flag_o[k] is set with en_o[k-1] set, irq_o goes high at the next edge for exactly one cycle. The global flag becomes 1 at that same edge.
- R5: While flag_o[0] is 1, irq_o stays low, however many enabled events arrive.
- R6: A clr_we write clears each flag whose bit in clr_wdata is 1 (bit 0 is the global flag, bits 7:1 are the event flags) and leaves the other flags unchanged. If an event or a force sets a flag in the same cycle as a clear of that flag, the flag stays set.
- R7: A frc_we write sets event flag k+1 for each bit k that is 1 in frc_wdata. It never clears a flag.
- R8: If the global flag is cleared while an enabled event flag is still set, a new pulse follows one cycle after the clear takes effect.
- R9: An en_we write loads en_wdata into en_o at the next edge. A flagged event whose enable bit is 0 never causes a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Event pulses: capture 1..4, period match, compare match |
| cnt_i | input | CNT_W | Counter value, watched for wrap to zero |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 7 | Enable bits, one per source |
| clr_we | input | 1 | Clear register write strobe |
| clr_wdata | input | 8 | Write-one-to-clear bits, bit 0 is the global flag |
| frc_we | input | 1 | Force register write strobe |
| frc_wdata | input | 7 | Write-one-to-set event flags |
| en_o | output | 7 | Current enable register |
| flag_o | output | 8 | Event flags in bits 7:1, global flag in bit 0 |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check the following on every cycle:
- a pulse lasts a single cycle and is always accompanied by the global flag;
- no pulse follows a cycle in which the global flag was set;
- a pulse always has an enabled, flagged source behind it;
- event and force writes always leave their flags set;
- uncleared flags are sticky.

The bench's scenarios are needed for the rest: the wrap detection on the counter, the precedence of an event over a simultaneous clear, the re-issued pulse after a global clear, and the silence of disabled sources. There, a reference model follows the register writes over directed and random sequences.

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       evt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             en_we,
  input  logic [6:0]       en_wdata,
  input  logic             clr_we,
  input  logic [7:0]       clr_wdata,
  input  logic             frc_we,
  input  logic [6:0]       frc_wdata,
  output logic [6:0]       en_o,
  output logic [7:0]       flag_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_prev;
  logic [6:0] en_q, evf_q, hw_set, clr_ev, frc_ev;
  logic       gflag_q, irq_q, wrap, fire, clr_g;

  assign wrap   = (&cnt_prev) && (cnt_i == '0);
  assign hw_set = {evt_i[5], evt_i[4], wrap, evt_i[3:0]};
  assign clr_ev = clr_we ? clr_wdata[7:1] : 7'd0;
  assign clr_g  = clr_we & clr_wdata[0];
  assign frc_ev = frc_we ? frc_wdata : 7'd0;
  assign fire   = !gflag_q && |(evf_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_prev <= '0;
      en_q     <= '0;
      evf_q    <= '0;
      gflag_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      cnt_prev <= cnt_i;
      if (en_we) en_q <= en_wdata;
      evf_q    <= (evf_q & ~clr_ev) | hw_set | frc_ev;
      gflag_q  <= (gflag_q & ~clr_g) | fire;
      irq_q    <= fire;
    end
  end

  assign en_o   = en_q;
  assign flag_o = {evf_q, gflag_q};
  assign irq_o  = irq_q;
endmodule

// File: rtl/evt_irq_ctl_chk.sv
module evt_irq_ctl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       evt_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             en_we,
  input logic [6:0]       en_wdata,
  input logic             clr_we,
  input logic [7:0]       clr_wdata,
  input logic             frc_we,
  input logic [6:0]       frc_wdata,
  input logic [6:0]       en_o,
  input logic [7:0]       flag_o,
  input logic             irq_o
);
  logic [6:0] keep, hw_map, frc_map;
  assign keep    = flag_o[7:1] & ~(clr_we ? clr_wdata[7:1] : 7'd0);
  assign hw_map  = {evt_i[5], evt_i[4], 1'b0, evt_i[3:0]};
  assign frc_map = frc_we ? frc_wdata : 7'd0;

  a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r4_global_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o[0]);
  a_r5_no_pulse_when_global: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o[0] |=> !irq_o);
  a_r9_pulse_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o ##1 irq_o |-> $past(|(flag_o[7:1] & en_o)));
  a_r2_hw_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_map) |=> ((flag_o[7:1] & $past(hw_map)) == $past(hw_map)));
  a_r7_force_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    frc_we |=> ((flag_o[7:1] & $past(frc_map)) == $past(frc_map)));
  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|keep) |=> ((flag_o[7:1] & $past(keep)) == $past(keep)));
endmodule

bind evt_irq_ctl evt_irq_ctl_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/evt_irq_ctl_tb_top.sv
module evt_irq_ctl_tb_top;
  localparam int CW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] evt_i = '0;
  logic [CW-1:0] cnt_i = '0;
  logic en_we = 0, clr_we = 0, frc_we = 0;
  logic [6:0] en_wdata = '0, frc_wdata = '0;
  logic [7:0] clr_wdata = '0;
  logic [6:0] en_o;
  logic [7:0] flag_o;
  logic irq_o;
  int checks = 0, errors = 0;

  logic [6:0] m_en = '0, m_evf = '0;
  logic m_g = 0, m_irq = 0;
  logic [CW-1:0] m_prev = '0;

  always #2.5 clk = ~clk;

  evt_irq_ctl #(.CNT_W(CW)) dut_i (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [6:0] hw;
    logic fire;
    hw   = {evt_i[5], evt_i[4], ((&m_prev) && cnt_i == '0), evt_i[3:0]};
    fire = !m_g && |(m_evf & m_en);
    m_irq = fire;
    m_g   = (m_g & ~(clr_we & clr_wdata[0])) | fire;
    m_evf = (m_evf & ~(clr_we ? clr_wdata[7:1] : 7'd0)) | hw | (frc_we ? frc_wdata : 7'd0);
    if (en_we) m_en = en_wdata;
    m_prev = cnt_i;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, " flag"}, {8'd0, flag_o}, {8'd0, m_evf, m_g});
    chk({tag, " en"}, {9'd0, en_o}, {9'd0, m_en});
    chk({tag, " irq"}, {15'd0, irq_o}, {15'd0, m_irq});
    evt_i = '0; en_we = 0; clr_we = 0; frc_we = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flag", {8'd0, flag_o}, 16'd0);
    chk("R1 en", {9'd0, en_o}, 16'd0);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);

    evt_i = 6'h02; tick("R2");
    chk("R2 cap2 flag", {8'd0, flag_o}, 16'h0004);
    tick("R9"); tick("R9");
    chk("R9 disabled no pulse", {15'd0, irq_o}, 16'd0);

    cnt_i = 5; tick("R3"); cnt_i = 0; tick("R3");
    chk("R3 no wrap", {15'd0, flag_o[5]}, 16'd0);
    cnt_i = '1; tick("R3"); cnt_i = 0; tick("R3");
    chk("R3 wrap", {15'd0, flag_o[5]}, 16'd1);

    en_we = 1; en_wdata = 7'h7F; tick("R9");
    tick("R4");
    chk("R4 pulse", {14'd0, irq_o, flag_o[0]}, 16'h0003);
    tick("R4");
    chk("R4 one cycle", {15'd0, irq_o}, 16'd0);

    evt_i = 6'h3F; tick("R5"); tick("R5"); tick("R5");
    chk("R5 blocked", {15'd0, irq_o}, 16'd0);

    clr_we = 1; clr_wdata = 8'hFE; evt_i = 6'h01; tick("R6");
    chk("R6 event wins", {8'd0, flag_o}, 16'h0003);
    clr_we = 1; clr_wdata = 8'h01; tick("R8"); tick("R8");
    chk("R8 repulse", {15'd0, irq_o}, 16'd1);

    clr_we = 1; clr_wdata = 8'hFF; en_we = 1; en_wdata = 7'h00; tick("R6");
    frc_we = 1; frc_wdata = 7'h55; tick("R7");
    chk("R7 force", {8'd0, flag_o}, 16'h00AA);
    tick("R9");

    for (int i = 0; i < 4000; i++) begin
      evt_i = (($urandom % 4) == 0) ? 6'($urandom) : 6'd0;
      cnt_i = (($urandom % 8) == 0) ? (($urandom % 2) ? '1 : '0) : CW'($urandom);
      en_we = ($urandom % 16) == 0; en_wdata = 7'($urandom);
      clr_we = ($urandom % 5) == 0; clr_wdata = 8'($urandom);
      frc_we = ($urandom % 20) == 0; frc_wdata = 7'($urandom);
      tick("R4 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule